// File: doc/BRIEF.md
# Serial Sampling Converter Target Model

This block stands in for the digital face of a serial sampling converter. It is synthesizable logic for use as a bus functional target. A host drives an active-low chip select and a serial clock into it. Both pins are asynchronous to the block's own clock, which runs faster and oversamples them. On every falling chip select, the block captures the parallel sample on its input. It then shifts out, on a single data pin, the word captured in the previous complete frame.

Each frame begins with leading zeros. Their number depends on the serial clock level when chip select falls: one zero if the clock is low, two if it is high. The data word follows, most significant bit first, and zeros fill every extra clock edge. A frame that closes before its sixteenth falling clock edge discards its sample. The block signals this with a one-cycle pulse and marks the held word as no longer valid. The next frame then shifts out the older, stale word.

Top module: `adc_emu_target`

## Requirements
- R1: While chip select is high (inactive), `sdo_en` is 0 and `sdo` is 0 (the idle level).
- R2: The first bit of a frame, present as soon as `sdo_en` rises, is a 0.
- R3: If `sclk_pin` is low when chip select falls, exactly one leading 0 precedes the data word. The MSB appears after the first falling clock edge.
- R4: If `sclk_pin` is high when chip select falls, two leading 0s precede the data word. The MSB appears after the second falling clock edge.
- R5: Each falling `sclk_pin` edge during a frame presents the next bit of the 14-bit word, MSB first.
- R6: After the LSB, `sdo` stays 0 for every further falling clock edge in the frame.
- R7: The word shifted out in a frame is the `sample_in` value captured when chip select fell at the start of the most recent complete frame. The word is zero if no frame has completed since reset.
- R8: If chip select rises before the 16th falling clock edge of a frame, `lost_sample` pulses for one cycle and `held_valid` drops to 0. The sample from that frame is discarded, so the next frame shifts out the older word.
- R9: After reset, `sdo_en` and `held_valid` are 0, `sdo` is 0, and the held word is zero.
- R10: Both pins pass through two synchronizer flops. `sdo_en` is still 0 after the second rising clock edge following a falling chip select pin, and is 1 after the third.
- R11: A frame that reaches its 16th falling clock edge sets `held_valid` to 1 once chip select returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_pin | input | 1 | Asynchronous chip select from host, active low |
| sclk_pin | input | 1 | Asynchronous serial clock from host |
| sample_in | input | 14 | Parallel sample captured at frame start |
| sdo | output | 1 | Serial data output |
| sdo_en | output | 1 | High while a frame is in progress and `sdo` carries frame bits |
| lost_sample | output | 1 | One-cycle pulse when a frame ends early |
| held_valid | output | 1 | The held word comes from a complete frame |

## Verification
The assertions run on every cycle and cover these properties:
- The first frame bit is zero.
- The output enable only follows a low synchronized chip select.
- The lost pulse lasts one cycle and closes the frame.
- The bit counter only moves on a clock fall.
- The word being shifted stays stable inside a frame.
- Completion and loss set and clear the valid flag.

Only the bench's scenarios can show the rest:
- The full bit order under each leading-zero mode.
- The trailing zeros.
- The one-frame lag of the data.
- Stale data after a lost frame.
- The exact synchronizer latency.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

    localparam int MAX_W   = 32;
    localparam int IDX_W   = $clog2(MAX_W);

    typedef enum logic {
        LEAD_ONE = 1'b0,
        LEAD_TWO = 1'b1
    } lead_e;

    function automatic int lead_zeros(input lead_e lead);
        return (lead == LEAD_TWO) ? 2 : 1;
    endfunction

    // Bit at position pos of a frame: leading zeros, word MSB first, then zeros.
    function automatic logic serial_bit(input logic [MAX_W-1:0] word,
                                        input int width,
                                        input int pos,
                                        input lead_e lead);
        int lz;
        logic [IDX_W-1:0] idx;
        lz  = lead_zeros(lead);
        idx = IDX_W'(width - 1 - (pos - lz));
        if (pos < lz)              return 1'b0;
        if (pos >= lz + width)     return 1'b0;
        return word[idx];
    endfunction

endpackage

// File: rtl/adc_emu_sync.sv
module adc_emu_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {(STAGES+1){RST_VAL}};
        else     chain <= {chain[STAGES-1:0], async_in};
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~chain[STAGES];
    assign fall  = ~level & chain[STAGES];
endmodule

// File: rtl/adc_emu_frame.sv
module adc_emu_frame
    import adc_emu_pkg::*;
#(
    parameter int FRAME_FALLS = 16,
    parameter int CNT_W       = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             sclk_level,
    input  logic             sclk_fall,
    output logic             active,
    output lead_e            lead,
    output logic [CNT_W-1:0] pos,
    output logic             frame_start,
    output logic             frame_done,
    output logic             frame_lost
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_FALLS - 1);
    localparam logic [CNT_W-1:0] SAT_POS  = CNT_W'(FRAME_FALLS);

    logic complete;

    assign frame_start = cs_fall;
    assign frame_done  = active & sclk_fall & ~cs_fall & ~complete & (pos == LAST_POS);
    assign frame_lost  = active & cs_rise & ~complete & ~frame_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            lead     <= LEAD_ONE;
            pos      <= '0;
            complete <= 1'b0;
        end else if (cs_fall) begin
            active   <= 1'b1;
            lead     <= sclk_level ? LEAD_TWO : LEAD_ONE;
            pos      <= '0;
            complete <= 1'b0;
        end else if (cs_rise) begin
            active   <= 1'b0;
        end else if (active && sclk_fall) begin
            if (pos != SAT_POS) pos <= pos + 1'b1;
            if (frame_done)     complete <= 1'b1;
        end
    end

    // R8: a lost frame is reported once and closes the frame
    p_lost_single_r8: assert property (@(posedge clk) disable iff (rst)
        frame_lost |=> (!frame_lost && !active));

    // R5: the bit position only advances on a serial clock fall
    p_pos_steady_r5: assert property (@(posedge clk) disable iff (rst)
        (active && !sclk_fall && !cs_fall && !cs_rise) |=> $stable(pos));

    // R11: completion is signalled once per frame
    p_done_once_r11: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);
endmodule

// File: rtl/adc_emu_store.sv
module adc_emu_store #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              frame_done,
    input  logic              frame_lost,
    input  logic [DATA_W-1:0] sample_in,
    output logic [DATA_W-1:0] tx_word,
    output logic              held_valid
);
    logic [DATA_W-1:0] pending;
    logic [DATA_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending    <= '0;
            held       <= '0;
            tx_word    <= '0;
            held_valid <= 1'b0;
        end else begin
            if (frame_start) begin
                pending <= sample_in;
                tx_word <= held;
            end
            if (frame_done) begin
                held       <= pending;
                held_valid <= 1'b1;
            end else if (frame_lost) begin
                held_valid <= 1'b0;
            end
        end
    end

    // R11: a completed frame makes the held word valid
    p_valid_after_done_r11: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> held_valid);

    // R8: an early end invalidates the held word
    p_lost_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (frame_lost && !frame_done) |=> !held_valid);

    // R7: the word being shifted changes only at a frame start
    p_tx_steady_r7: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(tx_word));
endmodule

// File: rtl/adc_emu_target.sv
module adc_emu_target
    import adc_emu_pkg::*;
#(
    parameter int   DATA_W      = 14,
    parameter int   SYNC_STAGES = 2,
    parameter logic IDLE_LEVEL  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_pin,
    input  logic              sclk_pin,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sdo,
    output logic              sdo_en,
    output logic              lost_sample,
    output logic              held_valid
);
    localparam int FRAME_FALLS = DATA_W + 2;
    localparam int CNT_W       = $clog2(FRAME_FALLS + 1);

    logic cs_lvl, cs_rise, cs_fall;
    logic sclk_lvl, sclk_rise_unused, sclk_fall;
    logic active, frame_start, frame_done, frame_lost;
    lead_e lead;
    logic [CNT_W-1:0] pos;
    logic [DATA_W-1:0] tx_word;

    adc_emu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst(rst), .async_in(cs_n_pin),
        .level(cs_lvl), .rise(cs_rise), .fall(cs_fall)
    );

    adc_emu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
        .clk(clk), .rst(rst), .async_in(sclk_pin),
        .level(sclk_lvl), .rise(sclk_rise_unused), .fall(sclk_fall)
    );

    adc_emu_frame #(.FRAME_FALLS(FRAME_FALLS), .CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst(rst),
        .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sclk_level(sclk_lvl), .sclk_fall(sclk_fall),
        .active(active), .lead(lead), .pos(pos),
        .frame_start(frame_start), .frame_done(frame_done), .frame_lost(frame_lost)
    );

    adc_emu_store #(.DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst),
        .frame_start(frame_start), .frame_done(frame_done), .frame_lost(frame_lost),
        .sample_in(sample_in), .tx_word(tx_word), .held_valid(held_valid)
    );

    always_comb begin
        if (active) sdo = serial_bit(MAX_W'(tx_word), DATA_W, int'(pos), lead);
        else        sdo = IDLE_LEVEL;
    end

    assign sdo_en      = active;
    assign lost_sample = frame_lost;

    // R2: the first bit on the pin is a zero
    p_start_zero_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_en) |-> !sdo);

    // R1: the output is enabled only after chip select was seen low
    p_en_after_low_r1: assert property (@(posedge clk) disable iff (rst)
        sdo_en |-> !$past(cs_lvl));
endmodule

// File: tb/sim_adc_emu_target.sv
module sim_adc_emu_target;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 14;
    localparam int SETTLE     = 5;
    localparam int NV         = 8;

    localparam logic [W-1:0] VEC_SAMPLE [NV] = '{14'h2AAB, 14'h1555, 14'h3FFF, 14'h0001,
                                                  14'h2000, 14'h1234, 14'h0F0F, 14'h3C3C};
    localparam logic         VEC_LEAD2  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1,
                                                  1'b0, 1'b1, 1'b1, 1'b0};
    localparam int           VEC_FALLS  [NV] = '{16, 16, 18, 16, 10, 16, 20, 16};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n_pin = 1'b1;
    logic sclk_pin = 1'b0;
    logic [W-1:0] sample_in = '0;
    logic sdo, sdo_en, lost_sample, held_valid;

    int checks = 0;
    int fails  = 0;
    int lost_seen = 0;
    int lost_exp  = 0;
    logic [W-1:0] exp_held = '0;
    logic         exp_valid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_emu_target u0 (
        .clk(clk), .rst(rst), .cs_n_pin(cs_n_pin), .sclk_pin(sclk_pin),
        .sample_in(sample_in), .sdo(sdo), .sdo_en(sdo_en),
        .lost_sample(lost_sample), .held_valid(held_valid)
    );

    always @(negedge clk) if (!rst && lost_sample) lost_seen++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic model_bit(input logic [W-1:0] word, input logic two, input int p);
        int lz;
        lz = two ? 2 : 1;
        if (p < lz || p >= lz + W) return 1'b0;
        return word[W-1-(p-lz)];
    endfunction

    function automatic string tag_of(input logic two, input int p);
        int lz;
        lz = two ? 2 : 1;
        if (p == 0)      return "R2";
        if (p < lz)      return "R4";
        if (p < lz + W)  return two ? "R5/R4" : "R5/R3";
        return "R6";
    endfunction

    task automatic run_frame(input logic [W-1:0] s, input logic two, input int falls);
        logic [W-1:0] sent;
        logic [W-1:0] got;
        int lz;
        sent = exp_held;
        got  = '0;
        lz   = two ? 2 : 1;
        sample_in = s;
        sclk_pin  = two;
        settle(SETTLE);
        cs_n_pin = 1'b0;
        settle(SETTLE);
        check("R2 sdo_en", {31'd0, sdo_en}, 32'd1);
        check(tag_of(two, 0), {31'd0, sdo}, {31'd0, model_bit(sent, two, 0)});
        for (int k = 1; k <= falls; k++) begin
            if (sclk_pin == 1'b0) begin
                sclk_pin = 1'b1;
                settle(SETTLE);
            end
            sclk_pin = 1'b0;
            settle(SETTLE);
            check(tag_of(two, k), {31'd0, sdo}, {31'd0, model_bit(sent, two, k)});
            if (k >= lz && k < lz + W) got[W-1-(k-lz)] = sdo;
        end
        if (falls >= lz + W - 1 + 1)
            check("R7 word", {18'd0, got}, {18'd0, sent});
        cs_n_pin = 1'b1;
        settle(SETTLE);
        check("R1 idle en", {31'd0, sdo_en}, 32'd0);
        check("R1 idle sdo", {31'd0, sdo}, 32'd0);
        if (falls >= W + 2) begin
            exp_held  = s;
            exp_valid = 1'b1;
            check("R11 valid", {31'd0, held_valid}, {31'd0, exp_valid});
        end else begin
            exp_valid = 1'b0;
            lost_exp++;
            check("R8 valid", {31'd0, held_valid}, {31'd0, exp_valid});
            check("R8 lost pulses", lost_seen, lost_exp);
        end
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        settle(3);
        rst = 1'b0;
        settle(2);
        // R9: reset state
        check("R9 sdo_en", {31'd0, sdo_en}, 32'd0);
        check("R9 sdo", {31'd0, sdo}, 32'd0);
        check("R9 held_valid", {31'd0, held_valid}, 32'd0);
        check("R9 lost", lost_seen, 0);

        // R10: synchronizer latency on chip select
        sclk_pin = 1'b0;
        settle(SETTLE);
        cs_n_pin = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        check("R10 en after 2 edges", {31'd0, sdo_en}, 32'd0);
        @(posedge clk); #1;
        check("R10 en after 3 edges", {31'd0, sdo_en}, 32'd1);
        // R9: first frame shifts the zero word; close it early (R8)
        check("R9 first bit", {31'd0, sdo}, 32'd0);
        settle(SETTLE);
        cs_n_pin = 1'b1;
        settle(SETTLE);
        lost_exp++;
        check("R8 lost early", lost_seen, lost_exp);
        check("R8 valid early", {31'd0, held_valid}, 32'd0);

        // vector table
        for (int v = 0; v < NV; v++)
            run_frame(VEC_SAMPLE[v], VEC_LEAD2[v], VEC_FALLS[v]);

        // R8: frame after a lost one ships the stale word, then recovers (R7)
        run_frame(14'h0AAA, 1'b0, 4);
        run_frame(14'h1111, 1'b1, 16);
        run_frame(14'h2222, 1'b0, 16);

        // R1: serial clock activity while deselected leaves the pin idle
        for (int k = 0; k < 3; k++) begin
            sclk_pin = ~sclk_pin;
            settle(SETTLE);
            check("R1 deselected", {30'd0, sdo_en, sdo}, 32'd0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule